// File: doc/BRIEF.md
# Integer Execute-Stage ALU

A purely combinational 32-bit arithmetic and logic unit for the execute stage of a small load/store integer pipeline. Each cycle the stage presents two operands, a 5-bit shift count taken from the instruction word and an operation code. The unit answers in the same cycle with a result word and a signed-overflow flag. The trap logic elsewhere in the pipeline decides what the flag causes.

The operations are:

- three shift kinds, each with either an instruction-supplied or an operand-supplied count;
- add and subtract in trapping and non-trapping flavours;
- four bitwise functions;
- signed and unsigned less-than;
- placement of a 16-bit immediate in the upper half of the word.

Immediate-form instructions reuse these codes. The decoder routes the extended immediate onto the second operand.

Top module: `alu_core`

## Requirements
- R1: Codes 0, 1 and 2 shift `opb` left (zero fill), right (zero fill) and right (sign fill) by `shamt`. For these codes the value of `opa` has no effect.
- R2: Codes 3, 4 and 5 perform the same three shifts of `opb`, with the count taken from `opa[4:0]`. The upper bits of `opa` and the value of `shamt` have no effect.
- R3: Code 6 (add) and code 8 (subtract, `opa - opb`) return the wrapped 32-bit result. They raise `ovf` exactly when the true signed result does not fit in 32 bits.
- R4: Code 7 (add) and code 9 (subtract) return the same wrapped result as codes 6 and 8, with `ovf` held at 0.
- R5: Codes 10, 11, 12 and 13 return bitwise AND, OR, XOR and NOR of `opa` and `opb`.
- R6: Code 14 returns 1 when `opa < opb` as two's-complement numbers and 0 otherwise. Code 15 does the same for unsigned numbers. Bits 31..1 of the result are always 0.
- R7: Code 16 returns `opb[15:0]` in bits 31..16 and zeros in bits 15..0. The value of `opa` has no effect.
- R8: Codes 17 to 31 return a zero result with `ovf` at 0.
- R9: `ovf` is 0 for every code other than 6 and 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code (see requirements) |
| opa | input | 32 | First operand; count source for register shifts |
| opb | input | 32 | Second operand; shifted value; immediate for code 16 |
| shamt | input | 5 | Instruction-supplied shift count |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed overflow of codes 6 and 8 |

## Verification
The shift tests use sign-set and sign-clear values at counts 0, 1, 16 and 31. These patterns separate the zero fill from the sign fill and the left shift from the reversed right shift. In the register shifts, junk in the upper count bits and a conflicting `shamt` show that only `opa[4:0]` is used. The add and subtract tests sit on the signed boundaries (largest positive plus one, most negative minus one, zero minus most negative). At these points the checked codes must flag and the unchecked codes must not, while both return the same sum. The compare tests pair -1 with 1, so signed and unsigned ordering give opposite answers. A pseudo-random sweep over every code, including the unused ones, is checked against an independent model.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [4:0] {
    OP_SLL  = 5'd0,
    OP_SRL  = 5'd1,
    OP_SRA  = 5'd2,
    OP_SLLV = 5'd3,
    OP_SRLV = 5'd4,
    OP_SRAV = 5'd5,
    OP_ADD  = 5'd6,
    OP_ADDU = 5'd7,
    OP_SUB  = 5'd8,
    OP_SUBU = 5'd9,
    OP_AND  = 5'd10,
    OP_OR   = 5'd11,
    OP_XOR  = 5'd12,
    OP_NOR  = 5'd13,
    OP_SLT  = 5'd14,
    OP_SLTU = 5'd15,
    OP_LUI  = 5'd16
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT = 2'd0,
    SH_RLOG = 2'd1,
    SH_RARI = 2'd2
  } shift_kind_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_kind_e;

  // Signed overflow of a two's-complement addition, from sign bits only.
  function automatic logic sign_overflow(input logic a_msb, input logic b_msb,
                                         input logic s_msb);
    return (a_msb == b_msb) && (s_msb != a_msb);
  endfunction

  // Signed less-than from the difference sign and its overflow.
  function automatic logic signed_less(input logic diff_msb, input logic sub_ovf);
    return diff_msb ^ sub_ovf;
  endfunction

  // Unsigned less-than: no carry out of a - b means a borrow occurred.
  function automatic logic unsigned_less(input logic carry_out);
    return ~carry_out;
  endfunction

endpackage

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  shift_kind_e   kind,
  output logic [W-1:0]  dout
);

  logic [W-1:0] din_rev;
  logic [W-1:0] stage [0:AW];
  logic [W-1:0] stage_rev;
  logic         fill_bit;

  assign fill_bit = (kind == SH_RARI) & din[W-1];

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign din_rev[i]   = din[W-1-i];
    assign stage_rev[i] = stage[AW][W-1-i];
  end

  // A left shift is a right shift of the bit-reversed word.
  assign stage[0] = (kind == SH_LEFT) ? din_rev : din;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amt[s] ? {{STEP{fill_bit}}, stage[s][W-1:STEP]} : stage[s];
  end

  assign dout = (kind == SH_LEFT) ? stage_rev : stage[AW];

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry_out,
  output logic         ovf_raw
);

  logic [W-1:0] b_eff;

  assign b_eff = sub ? ~b : b;
  assign {carry_out, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
  assign ovf_raw = sign_overflow(a[W-1], b_eff[W-1], sum[W-1]);

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_kind_e  kind,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (kind)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      default: y = ~(a | b);
    endcase
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [4:0]               op_sel,
  input  logic [WIDTH-1:0]         opa,
  input  logic [WIDTH-1:0]         opb,
  input  logic [$clog2(WIDTH)-1:0] shamt,
  output logic [WIDTH-1:0]         result,
  output logic                     ovf
);

  localparam int SHW  = $clog2(WIDTH);
  localparam int HALF = WIDTH / 2;

  alu_op_e      op;
  logic         op_shift_imm;
  logic         op_shift_reg;
  logic         op_is_shift;
  logic         op_is_addsub;
  logic         op_is_logic;
  logic         op_checked;
  logic         op_valid;
  logic         use_sub;
  shift_kind_e  sh_kind;
  logic [SHW-1:0]   sh_amt;
  logic [WIDTH-1:0] sh_out;
  logic [WIDTH-1:0] as_sum;
  logic             as_carry;
  logic             as_ovf;
  logic             lt_s;
  logic             lt_u;
  logic_kind_e      lg_kind;
  logic [WIDTH-1:0] lg_out;
  logic [WIDTH-1:0] lui_val;

  assign op = alu_op_e'(op_sel);

  // Decode
  assign op_shift_imm = (op_sel <= 5'd2);
  assign op_shift_reg = (op_sel >= 5'd3) && (op_sel <= 5'd5);
  assign op_is_shift  = op_shift_imm | op_shift_reg;
  assign op_is_addsub = (op_sel >= 5'd6) && (op_sel <= 5'd9);
  assign op_is_logic  = (op_sel >= 5'd10) && (op_sel <= 5'd13);
  assign op_checked   = (op == OP_ADD) || (op == OP_SUB);
  assign op_valid     = (op_sel <= 5'd16);
  assign use_sub      = (op == OP_SUB) || (op == OP_SUBU) ||
                        (op == OP_SLT) || (op == OP_SLTU);

  always_comb begin
    unique case (op)
      OP_SLL, OP_SLLV: sh_kind = SH_LEFT;
      OP_SRA, OP_SRAV: sh_kind = SH_RARI;
      default:         sh_kind = SH_RLOG;
    endcase
  end

  assign sh_amt  = op_shift_reg ? opa[SHW-1:0] : shamt;
  assign lg_kind = logic_kind_e'(op_sel[1:0] - 2'd2);
  assign lui_val = {opb[HALF-1:0], {(WIDTH-HALF){1'b0}}};

  alu_shifter #(.W(WIDTH), .AW(SHW)) u_shift (
    .din  (opb),
    .amt  (sh_amt),
    .kind (sh_kind),
    .dout (sh_out)
  );

  alu_addsub #(.W(WIDTH)) u_addsub (
    .a         (opa),
    .b         (opb),
    .sub       (use_sub),
    .sum       (as_sum),
    .carry_out (as_carry),
    .ovf_raw   (as_ovf)
  );

  alu_logic #(.W(WIDTH)) u_logic (
    .a    (opa),
    .b    (opb),
    .kind (lg_kind),
    .y    (lg_out)
  );

  assign lt_s = signed_less(as_sum[WIDTH-1], as_ovf);
  assign lt_u = unsigned_less(as_carry);

  always_comb begin
    result = '0;
    if (op_is_shift) begin
      result = sh_out;
    end else if (op_is_addsub) begin
      result = as_sum;
    end else if (op_is_logic) begin
      result = lg_out;
    end else if (op == OP_SLT) begin
      result = {{(WIDTH-1){1'b0}}, lt_s};
    end else if (op == OP_SLTU) begin
      result = {{(WIDTH-1){1'b0}}, lt_u};
    end else if (op == OP_LUI) begin
      result = lui_val;
    end
  end

  assign ovf = op_valid & op_checked & as_ovf;

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk (
  input logic [4:0]  op_sel,
  input logic [31:0] opa,
  input logic [31:0] opb,
  input logic [4:0]  shamt,
  input logic [31:0] result,
  input logic        ovf
);

  always_comb begin
    // R9
    no_overflow_chk: assert (!ovf || op_sel == 5'd6 || op_sel == 5'd8)
      else $error("ovf raised for code %0d", op_sel);
    // R6
    slt_bool_chk: assert (!(op_sel == 5'd14 || op_sel == 5'd15) || result[31:1] == '0)
      else $error("compare result not boolean: %h", result);
    // R7
    lui_low_zero_chk: assert (op_sel != 5'd16 || result[15:0] == 16'h0)
      else $error("upper-immediate low half nonzero: %h", result);
    // R8
    bad_op_zero_chk: assert (op_sel <= 5'd16 || (result == '0 && !ovf))
      else $error("unused code %0d gave %h", op_sel, result);
    // R3
    add_ovf_sign_chk: assert (!(op_sel == 5'd6 && ovf) ||
                              (opa[31] == opb[31] && result[31] != opa[31]))
      else $error("add overflow without sign conflict");
    // R5
    nor_disjoint_chk: assert (op_sel != 5'd13 || (result & (opa | opb)) == '0)
      else $error("nor result overlaps operands");
    // R2
    shift_zero_amt_chk: assert (!(op_sel >= 5'd3 && op_sel <= 5'd5 && opa[4:0] == 5'd0) ||
                                result == opb)
      else $error("register shift by zero altered value");
  end

endmodule

bind alu_core alu_core_chk u_chk (
  .op_sel (op_sel),
  .opa    (opa),
  .opb    (opb),
  .shamt  (shamt),
  .result (result),
  .ovf    (ovf)
);

// File: tb/alu_core_test.sv
module alu_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_sel = '0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;
  logic        ovf;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  alu_core uut (
    .op_sel (op_sel),
    .opa    (opa),
    .opb    (opb),
    .shamt  (shamt),
    .result (result),
    .ovf    (ovf)
  );

  // Independent model
  function automatic logic [31:0] model_res(input logic [4:0] c, input logic [31:0] a,
                                            input logic [31:0] b, input logic [4:0] s);
    logic [4:0] n;
    n = (c >= 5'd3 && c <= 5'd5) ? a[4:0] : s;
    case (c)
      5'd0, 5'd3: return b << n;
      5'd1, 5'd4: return b >> n;
      5'd2, 5'd5: return 32'($signed(b) >>> n);
      5'd6, 5'd7: return a + b;
      5'd8, 5'd9: return a - b;
      5'd10: return a & b;
      5'd11: return a | b;
      5'd12: return a ^ b;
      5'd13: return ~(a | b);
      5'd14: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      5'd15: return (a < b) ? 32'd1 : 32'd0;
      5'd16: return {b[15:0], 16'h0};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic model_ovf(input logic [4:0] c, input logic [31:0] a,
                                     input logic [31:0] b);
    longint wide;
    if (c == 5'd6)      wide = longint'($signed(a)) + longint'($signed(b));
    else if (c == 5'd8) wide = longint'($signed(a)) - longint'($signed(b));
    else return 1'b0;
    return (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] c, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] s);
    @(negedge clk);
    op_sel = c; opa = a; opb = b; shamt = s;
    #2;
  endtask

  task automatic run(input string req, input logic [4:0] c, input logic [31:0] a,
                     input logic [31:0] b, input logic [4:0] s);
    apply(c, a, b, s);
    check(req, result, model_res(c, a, b, s));
    check(req, {31'd0, ovf}, {31'd0, model_ovf(c, a, b)});
  endtask

  task automatic t_reset_state;
    apply(5'd0, 32'd0, 32'd0, 5'd0);
    check("R1 reset", result, 32'd0);
    check("R9 reset", {31'd0, ovf}, 32'd0);
  endtask

  task automatic t_shift_imm;
    apply(5'd0, 32'hFFFF_0000, 32'h0000_0001, 5'd31);
    check("R1 sll31", result, 32'h8000_0000);
    apply(5'd1, 32'h1234_5678, 32'h8000_0000, 5'd31);
    check("R1 srl31", result, 32'h0000_0001);
    apply(5'd2, 32'h0, 32'h8000_0000, 5'd16);
    check("R1 sra16", result, 32'hFFFF_8000);
    apply(5'd2, 32'h0, 32'h7000_0000, 5'd1);
    check("R1 sra pos", result, 32'h3800_0000);
    run("R1 sll0", 5'd0, 32'hDEAD_BEEF, 32'hCAFE_F00D, 5'd0);
  endtask

  task automatic t_shift_reg;
    apply(5'd3, 32'hFFFF_FFE4, 32'h0000_00F0, 5'd9);
    check("R2 sllv junk", result, 32'h0000_0F00);
    apply(5'd4, 32'h0000_0010, 32'hF000_0000, 5'd2);
    check("R2 srlv16", result, 32'h0000_F000);
    apply(5'd5, 32'hABCD_EF1F, 32'h8000_0000, 5'd0);
    check("R2 srav31", result, 32'hFFFF_FFFF);
    apply(5'd5, 32'h0000_0020, 32'h8765_4321, 5'd7);
    check("R2 srav amt0", result, 32'h8765_4321);
  endtask

  task automatic t_add_sub;
    apply(5'd6, 32'h7FFF_FFFF, 32'h1, 5'd0);
    check("R3 add res", result, 32'h8000_0000);
    check("R3 add ovf", {31'd0, ovf}, 32'd1);
    apply(5'd8, 32'h8000_0000, 32'h1, 5'd0);
    check("R3 sub res", result, 32'h7FFF_FFFF);
    check("R3 sub ovf", {31'd0, ovf}, 32'd1);
    apply(5'd8, 32'h0, 32'h8000_0000, 5'd0);
    check("R3 sub 0-min ovf", {31'd0, ovf}, 32'd1);
    apply(5'd6, 32'hFFFF_FFFF, 32'h1, 5'd0);
    check("R3 add no ovf", {31'd0, ovf}, 32'd0);
    check("R3 add wrap", result, 32'h0);
    apply(5'd7, 32'h7FFF_FFFF, 32'h1, 5'd0);
    check("R4 addu res", result, 32'h8000_0000);
    check("R4 addu ovf", {31'd0, ovf}, 32'd0);
    apply(5'd9, 32'h8000_0000, 32'h1, 5'd0);
    check("R4 subu res", result, 32'h7FFF_FFFF);
    check("R4 subu ovf", {31'd0, ovf}, 32'd0);
  endtask

  task automatic t_logic;
    apply(5'd10, 32'hF0F0_FF00, 32'hFF00_F0F0, 5'd3);
    check("R5 and", result, 32'hF000_F000);
    apply(5'd11, 32'hF0F0_FF00, 32'hFF00_F0F0, 5'd3);
    check("R5 or", result, 32'hFFF0_FFF0);
    apply(5'd12, 32'hF0F0_FF00, 32'hFF00_F0F0, 5'd3);
    check("R5 xor", result, 32'h0FF0_0FF0);
    apply(5'd13, 32'hF0F0_FF00, 32'hFF00_F0F0, 5'd3);
    check("R5 nor", result, 32'h000F_000F);
  endtask

  task automatic t_compare;
    apply(5'd14, 32'hFFFF_FFFF, 32'h1, 5'd0);
    check("R6 slt -1<1", result, 32'd1);
    apply(5'd15, 32'hFFFF_FFFF, 32'h1, 5'd0);
    check("R6 sltu", result, 32'd0);
    apply(5'd14, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0);
    check("R6 slt max<min", result, 32'd0);
    apply(5'd15, 32'h5, 32'h5, 5'd0);
    check("R6 sltu equal", result, 32'd0);
    check("R9 slt ovf", {31'd0, ovf}, 32'd0);
  endtask

  task automatic t_lui;
    apply(5'd16, 32'hFFFF_FFFF, 32'hABCD_1234, 5'd5);
    check("R7 lui", result, 32'h1234_0000);
    apply(5'd16, 32'h0, 32'hABCD_1234, 5'd0);
    check("R7 lui opa ignored", result, 32'h1234_0000);
  endtask

  task automatic t_unused;
    for (int c = 17; c < 32; c++) begin
      apply(5'(c), 32'h7FFF_FFFF, 32'h7FFF_FFFF, 5'd4);
      check("R8 unused res", result, 32'h0);
      check("R8 unused ovf", {31'd0, ovf}, 32'd0);
    end
  endtask

  task automatic t_sweep;
    logic [31:0] lf;
    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [31:0] b;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      a = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      b = (i % 5 == 0) ? {lf[31], lf[31], lf[29:0]} : lf * 32'd2654435761;
      run("R9 sweep", 5'(i % 32), a, b, lf[9:5]);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_shift_imm();
    t_shift_reg();
    t_add_sub();
    t_logic();
    t_compare();
    t_lui();
    t_unused();
    t_sweep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule